// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit address space built from 4 KB pages. A lookup presents a virtual address together with the access kind, read or write and user or supervisor. One cycle later the block answers with hit or miss. On a hit it returns the physical address and a protection-fault flag, and it says whether the page's dirty bit still has to be written back to the page table. On a miss it asks for a table walk.

Each entry keeps the translated page number and four combined permission flags: supervisor-only, writable, global and already-dirty. These flags are the combined result of both table levels. The lookup therefore judges access rights on its own. A page walker installs entries through a fill port. Two flush inputs serve task switches: one drops only the non-global entries, the other drops every entry.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid, rsp_valid_o is low, and every lookup misses until a fill is made.
- R2: A lookup that finds no matching valid entry answers with rsp_hit_o=0, rsp_walk_o=1, rsp_fault_o=0, rsp_dirty_upd_o=0 and rsp_pa_o=0.
- R3: rsp_valid_o is high in exactly the cycle after a cycle with lkup_valid_i high. On a hit, rsp_pa_o is the cached 20-bit page number in bits 31:12 and the unchanged offset lkup_va_i[11:0] in bits 11:0.
- R4: The page number is lkup_va_i[31:12]. Its bits 3:0 select one of 16 sets of 4 ways, and its bits 19:4 form the tag. The same tag in different sets gives independent entries, and at most one way of a set matches.
- R5: A hit raises rsp_fault_o when a user access (lkup_user_i=1) reaches a supervisor-only page, or when a write (lkup_write_i=1) reaches a non-writable page. A faulting hit never requests a dirty update.
- R6: rsp_dirty_upd_o is 1 only for a non-faulting write hit on an entry whose dirty flag is 0. It is 0 for reads and for entries whose dirty flag is 1.
- R7: A fill that matches no valid entry of its set takes the lowest-numbered invalid way. When the set is full, it takes the way named by that set's 2-bit round-robin pointer, which starts at 0 and steps by one after each such use.
- R8: A fill whose page number is already valid in its set overwrites that way in place and leaves the round-robin pointer unchanged.
- R9: flush_nonglobal_i invalidates every entry whose global flag is 0 and keeps global entries.
- R10: flush_all_i invalidates every entry in one cycle. A lookup made in the flush cycle still sees the contents from before the flush. A fill made in the same cycle as either flush is installed and survives that flush.
- R11: A lookup in the same cycle as a fill to the same set reports a miss with rsp_walk_o=1. The fill completes, and a later lookup hits. A fill to another set does not disturb the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkup_valid_i | input | 1 | Lookup request |
| lkup_va_i | input | 32 | Virtual address to translate |
| lkup_write_i | input | 1 | 1 = write access, 0 = read |
| lkup_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number of the fill |
| fill_ppn_i | input | 20 | Physical page number of the fill |
| fill_sup_i | input | 1 | Supervisor-only flag |
| fill_wr_i | input | 1 | Writable flag |
| fill_glb_i | input | 1 | Global flag |
| fill_dirty_i | input | 1 | Already-dirty flag |
| flush_nonglobal_i | input | 1 | Invalidate non-global entries |
| flush_all_i | input | 1 | Invalidate all entries |
| rsp_valid_o | output | 1 | Response present (one cycle after request) |
| rsp_hit_o | output | 1 | Translation found |
| rsp_pa_o | output | 32 | Physical address on a hit, else 0 |
| rsp_fault_o | output | 1 | Protection violation on a hit |
| rsp_dirty_upd_o | output | 1 | Write hit needs the page marked dirty |
| rsp_walk_o | output | 1 | Miss, page-table walk needed |

## Verification
Lookups use each pairing of read or write with user or supervisor against pages that differ in one flag at a time. This separates the supervisor test, the write test and the dirty-update decision. Pages that share a tag but sit in different sets show that indexing and tag matching are independent. Filling one set past its capacity, then refilling a page that is already present, separates invalid-first placement, round-robin eviction and in-place update. Lookups placed in a flush cycle or a fill cycle, and placed just after it, tell the pre-edge view apart from the post-edge view. They also show which entries each kind of flush removes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned PPN_W = 20;
  localparam int unsigned SETS  = 16;
  localparam int unsigned WAYS  = 4;

  typedef struct packed {
    logic glb;
    logic sup;
    logic wr;
    logic dirty;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PPN_W = 20,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_set_i,
  input  logic [WAY_W-1:0]      wr_way_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  logic [PPN_W-1:0]      wr_ppn_i,
  input  tlb_pkg::tlb_perm_t    wr_perm_i,
  input  logic                  flush_all_i,
  input  logic                  flush_ng_i,
  input  logic [IDX_W-1:0]      ra_set_i,
  output logic [WAYS-1:0]       ra_valid_o,
  output logic [TAG_W-1:0]      ra_tag_o [WAYS],
  output logic [PPN_W-1:0]      ra_ppn_o [WAYS],
  output tlb_pkg::tlb_perm_t    ra_perm_o [WAYS],
  input  logic [IDX_W-1:0]      rb_set_i,
  output logic [WAYS-1:0]       rb_valid_o,
  output logic [TAG_W-1:0]      rb_tag_o [WAYS]
);
  logic [WAYS-1:0]     valid_q [SETS];
  logic [TAG_W-1:0]    tag_q   [SETS][WAYS];
  logic [PPN_W-1:0]    ppn_q   [SETS][WAYS];
  tlb_pkg::tlb_perm_t  perm_q  [SETS][WAYS];
  logic [SETS*WAYS-1:0] valid_flat;

  // fill wins over a same-cycle flush for its own way
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (wr_en_i && wr_set_i == IDX_W'(s) && wr_way_i == WAY_W'(w))
            valid_q[s][w] <= 1'b1;
          else if (flush_all_i)
            valid_q[s][w] <= 1'b0;
          else if (flush_ng_i && !perm_q[s][w].glb)
            valid_q[s][w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_set_i][wr_way_i]  <= wr_tag_i;
      ppn_q[wr_set_i][wr_way_i]  <= wr_ppn_i;
      perm_q[wr_set_i][wr_way_i] <= wr_perm_i;
    end
  end

  always_comb begin
    ra_valid_o = valid_q[ra_set_i];
    rb_valid_o = valid_q[rb_set_i];
    for (int w = 0; w < WAYS; w++) begin
      ra_tag_o[w]  = tag_q[ra_set_i][w];
      ra_ppn_o[w]  = ppn_q[ra_set_i][w];
      ra_perm_o[w] = perm_q[ra_set_i][w];
      rb_tag_o[w]  = tag_q[rb_set_i][w];
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_flat_s
    for (genvar w = 0; w < WAYS; w++) begin : g_flat_w
      assign valid_flat[s*WAYS+w] = valid_q[s][w];
    end
  end

  p_flush_all_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i && !wr_en_i |=> valid_flat == '0);

  p_flush_ng_no_grow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ng_i && !wr_en_i |=> $countones(valid_flat) <= $past($countones(valid_flat)));
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [TAG_W-1:0] tag_i [WAYS],
  input  logic [TAG_W-1:0] key_i,
  output logic [WAYS-1:0]  hit_vec_o,
  output logic             hit_o,
  output logic [WAY_W-1:0] idx_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tag_i[w] == key_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    idx_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec_o[w]) idx_o = WAY_W'(w);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             use_i,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_idx_i,
  output logic [WAY_W-1:0] way_o
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic [WAY_W-1:0] free_idx;
  logic             any_free;
  logic             take_rr;

  assign any_free = ~&valid_i;

  always_comb begin
    free_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) free_idx = WAY_W'(w);
  end

  assign take_rr = !hit_i && !any_free;

  always_comb begin
    if (hit_i)         way_o = hit_idx_i;
    else if (any_free) way_o = free_idx;
    else               way_o = rr_q[set_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (use_i && take_rr) begin
      rr_q[set_i] <= rr_q[set_i] + 1'b1;
    end
  end

  p_free_way_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_i && !hit_i && any_free |-> !valid_i[way_o]);

  p_refill_in_place_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_i && hit_i |-> valid_i[way_o]);
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int unsigned VA_W  = tlb_pkg::VA_W,
  parameter int unsigned OFF_W = tlb_pkg::OFF_W,
  parameter int unsigned PPN_W = tlb_pkg::PPN_W,
  parameter int unsigned SETS  = tlb_pkg::SETS,
  parameter int unsigned WAYS  = tlb_pkg::WAYS,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PA_W  = PPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkup_valid_i,
  input  logic [VA_W-1:0]  lkup_va_i,
  input  logic             lkup_write_i,
  input  logic             lkup_user_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_sup_i,
  input  logic             fill_wr_i,
  input  logic             fill_glb_i,
  input  logic             fill_dirty_i,
  input  logic             flush_nonglobal_i,
  input  logic             flush_all_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_fault_o,
  output logic             rsp_dirty_upd_o,
  output logic             rsp_walk_o
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned WAY_W = $clog2(WAYS);

  // lookup side
  logic [VPN_W-1:0]   lk_vpn;
  logic [IDX_W-1:0]   lk_set;
  logic [TAG_W-1:0]   lk_tag;
  logic [WAYS-1:0]    ra_valid;
  logic [TAG_W-1:0]   ra_tag  [WAYS];
  logic [PPN_W-1:0]   ra_ppn  [WAYS];
  tlb_pkg::tlb_perm_t ra_perm [WAYS];
  logic [WAYS-1:0]    lk_hit_vec;
  logic               lk_hit;
  logic [WAY_W-1:0]   lk_way;
  tlb_pkg::tlb_perm_t lk_perm;
  logic               collide, hit_eff, fault_d, dirty_d;

  // fill side
  logic [IDX_W-1:0]   fl_set;
  logic [TAG_W-1:0]   fl_tag;
  logic [WAYS-1:0]    rb_valid;
  logic [TAG_W-1:0]   rb_tag [WAYS];
  logic [WAYS-1:0]    fl_hit_vec;
  logic               fl_hit;
  logic [WAY_W-1:0]   fl_hit_idx;
  logic [WAY_W-1:0]   fl_way;
  tlb_pkg::tlb_perm_t fl_perm;

  assign lk_vpn = lkup_va_i[VA_W-1:OFF_W];
  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set = fill_vpn_i[IDX_W-1:0];
  assign fl_tag = fill_vpn_i[VPN_W-1:IDX_W];
  assign fl_perm = '{glb: fill_glb_i, sup: fill_sup_i, wr: fill_wr_i, dirty: fill_dirty_i};

  tlb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(fill_valid_i), .wr_set_i(fl_set), .wr_way_i(fl_way),
    .wr_tag_i(fl_tag), .wr_ppn_i(fill_ppn_i), .wr_perm_i(fl_perm),
    .flush_all_i, .flush_ng_i(flush_nonglobal_i),
    .ra_set_i(lk_set), .ra_valid_o(ra_valid), .ra_tag_o(ra_tag),
    .ra_ppn_o(ra_ppn), .ra_perm_o(ra_perm),
    .rb_set_i(fl_set), .rb_valid_o(rb_valid), .rb_tag_o(rb_tag)
  );

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_i(ra_valid), .tag_i(ra_tag), .key_i(lk_tag),
    .hit_vec_o(lk_hit_vec), .hit_o(lk_hit), .idx_o(lk_way)
  );

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .valid_i(rb_valid), .tag_i(rb_tag), .key_i(fl_tag),
    .hit_vec_o(fl_hit_vec), .hit_o(fl_hit), .idx_o(fl_hit_idx)
  );

  tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk_i, .rst_ni,
    .use_i(fill_valid_i), .set_i(fl_set), .valid_i(rb_valid),
    .hit_i(fl_hit), .hit_idx_i(fl_hit_idx), .way_o(fl_way)
  );

  // a fill into the looked-up set takes the array; lookup reports a miss
  assign collide = fill_valid_i && (fl_set == lk_set);
  assign hit_eff = lk_hit && !collide;
  assign lk_perm = ra_perm[lk_way];
  assign fault_d = hit_eff && ((lkup_user_i && lk_perm.sup) || (lkup_write_i && !lk_perm.wr));
  assign dirty_d = hit_eff && !fault_d && lkup_write_i && !lk_perm.dirty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_hit_o       <= 1'b0;
      rsp_pa_o        <= '0;
      rsp_fault_o     <= 1'b0;
      rsp_dirty_upd_o <= 1'b0;
      rsp_walk_o      <= 1'b0;
    end else begin
      rsp_valid_o     <= lkup_valid_i;
      rsp_hit_o       <= lkup_valid_i && hit_eff;
      rsp_pa_o        <= (lkup_valid_i && hit_eff) ? {ra_ppn[lk_way], lkup_va_i[OFF_W-1:0]} : '0;
      rsp_fault_o     <= lkup_valid_i && fault_d;
      rsp_dirty_upd_o <= lkup_valid_i && dirty_d;
      rsp_walk_o      <= lkup_valid_i && !hit_eff;
    end
  end

  p_onehot_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_vec) && $onehot0(fl_hit_vec));

  p_rsp_follows_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_valid_i |=> rsp_valid_o);

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkup_valid_i |=> !rsp_valid_o && !rsp_hit_o);

  p_miss_walks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> rsp_walk_o && !rsp_fault_o && !rsp_dirty_upd_o && rsp_pa_o == '0);

  p_fault_blocks_dirty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_hit_o && !rsp_dirty_upd_o);

  p_read_never_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_valid_i && !lkup_write_i |=> !rsp_dirty_upd_o);

  p_collide_miss_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_valid_i && fill_valid_i && fill_vpn_i[IDX_W-1:0] == lkup_va_i[OFF_W+IDX_W-1:OFF_W]
    |=> !rsp_hit_o && rsp_walk_o);

  p_offset_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkup_valid_i |=> !rsp_hit_o || rsp_pa_o[OFF_W-1:0] == $past(lkup_va_i[OFF_W-1:0]));
endmodule

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkup_valid = 1'b0;
  logic [31:0] lkup_va = '0;
  logic        lkup_write = 1'b0;
  logic        lkup_user = 1'b0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_sup = 1'b0, fill_wr = 1'b0, fill_glb = 1'b0, fill_dirty = 1'b0;
  logic        flush_ng = 1'b0, flush_all = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_dirty, rsp_walk;
  logic [31:0] rsp_pa;

  always #4 clk = ~clk;

  xlat_tlb dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lkup_valid_i(lkup_valid), .lkup_va_i(lkup_va), .lkup_write_i(lkup_write), .lkup_user_i(lkup_user),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_sup_i(fill_sup), .fill_wr_i(fill_wr), .fill_glb_i(fill_glb), .fill_dirty_i(fill_dirty),
    .flush_nonglobal_i(flush_ng), .flush_all_i(flush_all),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_pa_o(rsp_pa),
    .rsp_fault_o(rsp_fault), .rsp_dirty_upd_o(rsp_dirty), .rsp_walk_o(rsp_walk)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  bit          m_v [16][4];
  logic [15:0] m_tag [16][4];
  logic [19:0] m_ppn [16][4];
  bit          m_g [16][4], m_s [16][4], m_w [16][4], m_d [16][4];
  int          m_rr [16];

  // {hit, walk, fault, dirty, pa}
  logic [35:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (hit,walk,fault,dirty,pa)", req, act, exp);
    end
  endtask

  task automatic step(input bit lk, input logic [31:0] va, input bit wr, input bit usr, input string req,
                      input bit fl, input logic [19:0] vpn, input logic [19:0] ppn,
                      input bit g, input bit s, input bit w, input bit d,
                      input bit fng, input bit fa);
    @(negedge clk);
    lkup_valid = lk; lkup_va = va; lkup_write = wr; lkup_user = usr;
    fill_valid = fl; fill_vpn = vpn; fill_ppn = ppn;
    fill_glb = g; fill_sup = s; fill_wr = w; fill_dirty = d;
    flush_ng = fng; flush_all = fa;
    if (lk) begin
      int st = int'(va[15:12]);
      bit found = 1'b0;
      int way = 0;
      bit hit, flt, dty;
      logic [31:0] pa;
      for (int i = 0; i < 4; i++)
        if (m_v[st][i] && m_tag[st][i] == va[31:16]) begin found = 1'b1; way = i; end
      hit = found && !(fl && int'(vpn[3:0]) == st);
      flt = hit && ((usr && m_s[st][way]) || (wr && !m_w[st][way]));
      dty = hit && !flt && wr && !m_d[st][way];
      pa  = hit ? {m_ppn[st][way], va[11:0]} : 32'h0;
      exp_q.push_back({hit, !hit, flt, dty, pa});
      tag_q.push_back(req);
    end
    begin
      int fs = int'(vpn[3:0]);
      int vw = -1;
      if (fl) begin
        for (int i = 0; i < 4; i++)
          if (m_v[fs][i] && m_tag[fs][i] == vpn[19:4]) vw = i;
        if (vw < 0)
          for (int i = 3; i >= 0; i--)
            if (!m_v[fs][i]) vw = i;
        if (vw < 0) begin vw = m_rr[fs]; m_rr[fs] = (m_rr[fs] + 1) % 4; end
      end
      for (int si = 0; si < 16; si++)
        for (int i = 0; i < 4; i++)
          if (fa || (fng && !m_g[si][i])) m_v[si][i] = 1'b0;
      if (fl) begin
        m_v[fs][vw] = 1'b1; m_tag[fs][vw] = vpn[19:4]; m_ppn[fs][vw] = ppn;
        m_g[fs][vw] = g; m_s[fs][vw] = s; m_w[fs][vw] = w; m_d[fs][vw] = d;
      end
    end
  endtask

  task automatic look(input logic [31:0] va, input bit wr, input bit usr, input string req);
    step(1'b1, va, wr, usr, req, 1'b0, '0, '0, 0, 0, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input bit g, input bit s, input bit w, input bit d);
    step(1'b0, '0, 1'b0, 1'b0, "", 1'b1, vpn, ppn, g, s, w, d, 1'b0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, "", 1'b0, '0, '0, 0, 0, 0, 0, 1'b0, 1'b0);
  endtask

  // monitor: result settles after the edge following the request
  always @(posedge clk) begin
    #2;
    if (rst_n && rsp_valid) begin
      logic [35:0] act;
      act = {rsp_hit, rsp_walk, rsp_fault, rsp_dirty, rsp_pa};
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", act, '0);
      end else begin
        logic [35:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check(act === e, r, act, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      m_rr[s] = 0;
      for (int i = 0; i < 4; i++) begin
        m_v[s][i] = 0; m_g[s][i] = 0; m_s[s][i] = 0; m_w[s][i] = 0; m_d[s][i] = 0;
        m_tag[s][i] = '0; m_ppn[s][i] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1",
          {rsp_hit, rsp_walk, rsp_fault, rsp_dirty, 32'h0}, '0);

    look(32'h1234_5678, 0, 1, "R1");
    fill(20'h12345, 20'hABCDE, 0, 0, 1, 0);
    look(32'h1234_5678, 0, 1, "R3");
    look(32'h1234_5ABC, 1, 1, "R6");
    look(32'h1234_4678, 0, 0, "R2");
    fill(20'h12346, 20'h11111, 0, 0, 1, 1);
    look(32'h1234_6001, 0, 0, "R4");
    look(32'h1234_5002, 0, 0, "R4");

    // protection
    fill(20'h54321, 20'h0F0F0, 1, 1, 0, 1);
    look(32'h5432_1010, 0, 1, "R5");
    look(32'h5432_1020, 0, 0, "R5");
    look(32'h5432_1030, 1, 0, "R5");
    look(32'h5432_1040, 1, 1, "R5");
    fill(20'h33337, 20'h77777, 0, 0, 1, 1);
    look(32'h3333_7FFF, 1, 1, "R6");
    look(32'h3333_7000, 0, 1, "R6");
    look(32'h1234_5000, 0, 0, "R6");

    // replacement in set 9
    fill(20'h10009, 20'hA0001, 0, 0, 1, 0);
    fill(20'h20009, 20'hA0002, 0, 0, 1, 0);
    fill(20'h30009, 20'hA0003, 0, 0, 1, 0);
    fill(20'h40009, 20'hA0004, 0, 0, 1, 0);
    look(32'h1000_9111, 0, 0, "R7");
    fill(20'h50009, 20'hA0005, 0, 0, 1, 0);
    look(32'h1000_9111, 0, 0, "R7");
    look(32'h5000_9222, 0, 0, "R7");
    look(32'h2000_9333, 0, 0, "R7");
    fill(20'h60009, 20'hA0006, 0, 0, 1, 0);
    look(32'h2000_9333, 0, 0, "R7");
    fill(20'h40009, 20'hBBBBB, 0, 0, 1, 0);
    look(32'h4000_9444, 0, 0, "R8");
    look(32'h3000_9555, 0, 0, "R8");
    fill(20'h70009, 20'hA0007, 0, 0, 1, 0);
    look(32'h3000_9555, 0, 0, "R8");
    look(32'h4000_9666, 0, 0, "R8");
    look(32'h7000_9777, 0, 0, "R7");

    // fill/lookup collisions
    step(1, 32'h8888_1234, 0, 0, "R11", 1, 20'h88881, 20'hCCCCC, 0, 0, 1, 0, 0, 0);
    look(32'h8888_1234, 0, 0, "R11");
    step(1, 32'h1234_5678, 0, 0, "R11", 1, 20'h99991, 20'hDDDDD, 0, 0, 1, 0, 0, 0);

    // non-global flush; lookup in the flush cycle sees old state
    step(1, 32'h1234_5678, 0, 0, "R10", 0, '0, '0, 0, 0, 0, 0, 1, 0);
    look(32'h1234_5678, 0, 0, "R9");
    look(32'h5432_1678, 0, 0, "R9");
    look(32'h8888_1678, 0, 0, "R9");

    // full flush with a same-cycle fill
    fill(20'h77772, 20'hEEEEE, 1, 0, 1, 0);
    step(1, 32'h5432_1000, 0, 0, "R10", 1, 20'h99990, 20'h12121, 0, 0, 1, 1, 0, 1);
    look(32'h5432_1000, 0, 0, "R10");
    look(32'h7777_2000, 0, 0, "R10");
    look(32'h9999_0ABC, 1, 1, "R10");
    step(0, '0, 0, 0, "", 1, 20'hABCD3, 20'h34343, 0, 0, 1, 0, 1, 0);
    look(32'hABCD_3FED, 0, 0, "R10");

    idle();
    idle();
    idle();
    if (exp_q.size() != 0) check(1'b0, "R3", 36'(exp_q.size()), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule